// File: doc/BRIEF.md
# Converter Result Capture with High/Low Read Interlock

This block takes finished results from a successive-approximation converter and presents them to a CPU as two byte-wide read-only registers. It also holds the 8-bit configuration register that sets the converter's resolution and operating options. The converter is modelled as a one-cycle `conv_done` strobe with a 10-bit `conv_data` bus. In 8-bit resolution the result is `conv_data[7:0]`. In 10-bit resolution the top two bits are `conv_data[9:8]`.

In 10-bit resolution a result spans both registers, so the block keeps a read pair coherent. Reading the high byte freezes both result registers, and the freeze stays until the low byte is read. Any conversion that finishes while the registers are frozen is dropped and is never visible. In 8-bit resolution there is no freeze, and every finished conversion replaces the registers.

Bus map: address 0 is the high result byte, address 1 is the low result byte, address 2 is the configuration register, and address 3 is unused. Reads are combinational: `bus_rdata` shows the addressed register while `bus_rd` is high and reads zero otherwise. Any state change caused by an access takes effect at the clock edge that ends the access cycle.

Top module: `adc_result_lock`

## Requirements
- R1: After reset, the high result, low result and configuration registers all read 0x00, and `low_power` is 0.
- R2: A write to address 2 stores all 8 bits of `bus_wdata`, and a read of address 2 returns them. The register's bit fields are: bit 7 low-power select, bits 6:5 divider, bit 4 clock source, bits 3:2 resolution mode, bit 1 long sample, bit 0 clock enable. `low_power` always equals bit 7.
- R3: With mode 01 (10-bit), a completed conversion makes the low register read `conv_data[7:0]` and the high register read `{6'b0, conv_data[9:8]}` from the next cycle on.
- R4: With mode 00 or 1x (8-bit), a completed conversion makes the low register read `conv_data[7:0]`, and the high register always reads 0x00.
- R5: In 10-bit mode, a read of address 0 sets the lock at the end of that bus cycle. A `conv_done` on that same cycle, or on any cycle while the lock is set, changes neither result register.
- R6: A read of address 1 clears the lock at the end of that cycle. A `conv_done` on that same cycle is dropped. The next `conv_done` after that is captured.
- R7: In 8-bit mode, a read of the high register sets no lock, so a conversion that completes after it is captured.
- R8: A write to the configuration register clears a pending lock.
- R9: Writes to addresses 0 and 1 are ignored. A read of address 1 while unlocked has no side effect.
- R10: A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | 10 | Converter result |
| low_power | output | 1 | Low-power select passed to the converter |

## Verification
A lock that sticks shows up at the next conversion: the low register keeps an old value after a release read, so the first read after it gives the wrong answer. A lock that never sets shows up one read later: a conversion completing between the high and low reads makes the low byte disagree with the high byte already returned. A lock set in 8-bit mode, or a strobe that slips through on a set or clear cycle, appears in the first low-byte read that follows.

// File: rtl/adc_lock_pkg.sv
package adc_lock_pkg;

    typedef enum logic [1:0] {
        ADDR_HI   = 2'd0,
        ADDR_LO   = 2'd1,
        ADDR_CFG  = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        MODE_8B   = 2'b00,
        MODE_10B  = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } mode_e;

    typedef struct packed {
        logic       low_pwr;
        logic [1:0] div_sel;
        logic       clk_src;
        mode_e      mode;
        logic       long_smp;
        logic       clk_on;
    } cfg_t;

endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
    import adc_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output cfg_t       cfg,
    output logic       wide
);

    typedef struct packed {
        cfg_t cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg  = st_q.cfg;
    assign wide = (st_q.cfg.mode == MODE_10B);

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg)); // R2
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg == cfg_t'($past(wdata)))); // R2

endmodule

// File: rtl/adc_lock_ctl.sv
module adc_lock_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_rd,
    input  logic lo_rd,
    input  logic wide,
    input  logic cfg_wr,
    output logic locked,
    output logic block
);

    typedef struct packed {
        logic lock;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.lock = 1'b0;
        end else if (lo_rd) begin
            st_d.lock = 1'b0;
        end else if (hi_rd && wide) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.lock;
    // The high-byte read cycle itself already refuses new results.
    assign block  = st_q.lock | (hi_rd & wide);

    AST_NO_LOCK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> !locked); // R7
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && wide && !cfg_wr) |=> locked); // R5
    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && lo_rd) |=> !locked); // R6
    AST_CFG_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !locked); // R8

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8,
    localparam int HI_W  = RES_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [RES_W-1:0]  data,
    input  logic              wide,
    input  logic              block,
    output logic [HI_W-1:0]   hi_bits,
    output logic [BYTE_W-1:0] lo_bits
);

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] lo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done && !block) begin
            st_d.lo = data[BYTE_W-1:0];
            st_d.hi = wide ? data[RES_W-1:BYTE_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_bits = st_q.hi;
    assign lo_bits = st_q.lo;

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> $stable({hi_bits, lo_bits})); // R5
    AST_NARROW_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide && !block) |=> (hi_bits == '0)); // R4
    AST_CAPTURE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !block) |=> (lo_bits == $past(data[BYTE_W-1:0]))); // R3

endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
    import adc_lock_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic              low_power
);

    localparam int HI_W = RES_W - BYTE_W;

    logic              hi_rd_d, lo_rd_d, cfg_wr_d;
    logic              wide, locked, block;
    cfg_t              cfg;
    logic [HI_W-1:0]   hi_bits;
    logic [BYTE_W-1:0] lo_bits;

    always_comb begin
        hi_rd_d  = bus_rd && (addr_e'(bus_addr) == ADDR_HI);
        lo_rd_d  = bus_rd && (addr_e'(bus_addr) == ADDR_LO);
        cfg_wr_d = bus_wr && (addr_e'(bus_addr) == ADDR_CFG);
    end

    adc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_d),
        .wdata (bus_wdata),
        .cfg   (cfg),
        .wide  (wide)
    );

    adc_lock_ctl u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_rd  (hi_rd_d),
        .lo_rd  (lo_rd_d),
        .wide   (wide),
        .cfg_wr (cfg_wr_d),
        .locked (locked),
        .block  (block)
    );

    adc_result_store #(
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (conv_done),
        .data    (conv_data),
        .wide    (wide),
        .block   (block),
        .hi_bits (hi_bits),
        .lo_bits (lo_bits)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (addr_e'(bus_addr))
                ADDR_HI:  bus_rdata = wide ? {{(BYTE_W-HI_W){1'b0}}, hi_bits} : '0;
                ADDR_LO:  bus_rdata = lo_bits;
                ADDR_CFG: bus_rdata = cfg;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign low_power = cfg.low_pwr;

    AST_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |-> (bus_rdata[BYTE_W-1:HI_W] == '0)); // R3
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == '0)); // R10
    AST_LOCK_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> wide); // R7

endmodule

// File: tb/adc_result_lock_test.sv
module adc_result_lock_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       low_power;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adc_result_lock uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .low_power (low_power)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // One bus cycle; optional done strobe on the same cycle.
    task automatic op(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] wd, input logic dn, input logic [9:0] dd,
                      output logic [7:0] rv);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        conv_done = dn; conv_data = dd;
        #1 rv = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; conv_done = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] rv);
        op(1'b1, 1'b0, a, 8'h00, 1'b0, 10'h0, rv);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        op(1'b0, 1'b1, a, d, 1'b0, 10'h0, dummy);
    endtask

    task automatic conv(input logic [9:0] d);
        logic [7:0] dummy;
        op(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, d, dummy);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); chk("R1 hi", v, 8'h00);
        rd(2'd1, v); chk("R1 lo", v, 8'h00);
        rd(2'd2, v); chk("R1 cfg", v, 8'h00);
        chk("R1 low_power", {7'b0, low_power}, 8'h00);

        // R2: full control register sweep
        for (int c = 0; c < 256; c++) begin
            wr(2'd2, c[7:0]);
            rd(2'd2, v); chk("R2 readback", v, c[7:0]);
            chk("R2 low_power", {7'b0, low_power}, {7'b0, c[7]});
        end

        // R3: exhaustive 10-bit capture
        wr(2'd2, 8'h04);
        for (int x = 0; x < 1024; x++) begin
            conv(x[9:0]);
            rd(2'd0, v); chk("R3 hi", v, 8'(x / 256));
            rd(2'd1, v); chk("R3 lo", v, 8'(x % 256));
        end

        // R4, R7: 8-bit mode (00 and reserved 11)
        for (int m = 0; m < 2; m++) begin
            wr(2'd2, (m == 0) ? 8'h00 : 8'h0C);
            for (int x = 0; x < 1024; x += 7) begin
                conv(x[9:0]);
                rd(2'd1, v); chk("R4 lo", v, 8'(x % 256));
                rd(2'd0, v); chk("R4 hi", v, 8'h00);
                conv(10'(x ^ 10'h155));
                rd(2'd1, v); chk("R7 no lock", v, 8'((x ^ 10'h155) % 256));
            end
        end

        // R5: results dropped while locked
        wr(2'd2, 8'h04);
        conv(10'h2A5);
        rd(2'd0, v); chk("R5 hi", v, 8'h02);
        conv(10'h15A);
        rd(2'd1, v); chk("R5 lo kept", v, 8'hA5);
        rd(2'd0, v); chk("R5 hi kept", v, 8'h02);
        rd(2'd1, v); chk("R5 lo after release", v, 8'hA5);

        // R5: strobe on the high-read cycle is dropped
        conv(10'h3C3);
        op(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 10'h03C, v); chk("R5 same-cycle hi", v, 8'h03);
        rd(2'd1, v); chk("R5 same-cycle lo", v, 8'hC3);

        // R6: strobe on the releasing low read is dropped, next one captured
        conv(10'h1E1);
        rd(2'd0, v); chk("R6 hi", v, 8'h01);
        op(1'b1, 1'b0, 2'd1, 8'h00, 1'b1, 10'h2F0, v); chk("R6 release lo", v, 8'hE1);
        rd(2'd1, v); chk("R6 dropped on release", v, 8'hE1);
        conv(10'h29B);
        rd(2'd0, v); chk("R6 next hi", v, 8'h02);
        rd(2'd1, v); chk("R6 next lo", v, 8'h9B);

        // R8: config write clears lock
        conv(10'h111);
        rd(2'd0, v); chk("R8 hi", v, 8'h01);
        wr(2'd2, 8'h04);
        conv(10'h2CD);
        rd(2'd1, v); chk("R8 lo after unlock", v, 8'hCD);

        // R9: result writes ignored, unlocked low read has no side effect
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R9 lo ro", v, 8'hCD);
        conv(10'h077);
        rd(2'd1, v); chk("R9 lo read free", v, 8'h77);
        rd(2'd0, v); chk("R9 hi ro", v, 8'h00);
        rd(2'd1, v);

        // R10: spare address
        rd(2'd3, v); chk("R10 spare", v, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule